// File: doc/BRIEF.md
# Trigger-Matched Time Window Extractor

This block collects timestamped hit words and sorts each one, as it arrives, into an on-chip page that belongs to one 25 ns time slot. Pages are addressed by the low bits of the absolute slot number. Each page also keeps the full slot number and a count of the hits it holds. A page that is reused by a later slot therefore never returns hits from an earlier pass around the ring.

A trigger carries the slot number of the interesting moment. Two window settings, captured together with the trigger, give how many slots before and after that slot belong to the event. The trigger waits until the current time has moved past the last slot of its window. It then reads the window from the earliest slot to the latest and emits one event packet on a valid/ready stream. The packet starts with a header word, carries the window's hits and ends with a trailer word. Hits outside every requested window are never forwarded. Triggers that arrive during a readout wait in a short queue. A trigger that finds the queue full is dropped and counted.

Top module: `trig_window_extractor`

## Requirements
- R1: After reset `out_valid` is 0 and `err_count` is 0.
- R2: A hit is stored in the page of its own slot. Within a packet, hits of one slot appear in arrival order, and slots appear in ascending order.
- R3: The window covers slots `trig_slot - win_before` through `trig_slot + win_after`. Each setting lies in 0 to 7 and is sampled in the cycle the trigger is accepted.
- R4: A slot keeps at most 8 hits. Further hits for that slot are discarded.
- R5: When a page is reused by a slot 256 later, a trigger that asks for the earlier slot receives no hits from that page.
- R6: No packet word is emitted for a trigger until `now_slot` is strictly greater than the last slot of its window.
- R7: A packet is a header (`out_kind` 01, data = trigger slot), then one word per hit (`out_kind` 10, data = hit data), then a trailer (`out_kind` 11, data = hit count, `out_last` 1). A header or trailer offered while `out_ready` is 0 stays unchanged.
- R8: Up to 4 accepted triggers wait in arrival order, and packets leave in that order.
- R9: A trigger that arrives while 4 triggers are waiting, and no readout starts in that cycle, is dropped. Each such drop raises `err_count` by one, and the count saturates at 255.
- R10: A trigger that arrives while the queue is full, in the same cycle that a waiting trigger starts its readout, is accepted.
- R11: Hits in slots outside every accepted trigger's window never appear on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now_slot | input | 16 | Current absolute time slot |
| hit_valid | input | 1 | Hit word present |
| hit_slot | input | 16 | Absolute slot of the hit |
| hit_data | input | 16 | Hit payload |
| trig_valid | input | 1 | Trigger present |
| trig_slot | input | 16 | Slot named by the trigger |
| win_before | input | 3 | Slots taken before the trigger slot |
| win_after | input | 3 | Slots taken after the trigger slot |
| out_valid | output | 1 | Packet word present |
| out_ready | input | 1 | Sink accepts the word |
| out_kind | output | 2 | Word type: 01 header, 10 hit, 11 trailer |
| out_data | output | 16 | Word payload |
| out_last | output | 1 | Marks the trailer word |
| err_count | output | 8 | Saturating count of dropped triggers |

## Verification
Two things can happen in one cycle: a new trigger can be pushed into the queue while the readout engine pops the head entry whose window has just closed. The bench fills the queue with four triggers that are still pending while the engine is idle. In a single cycle it then moves the time base past their slot and presents a fifth trigger. The reference model accepts that trigger only because of the pop in the same cycle. It is judged by an unchanged error count and by the fifth packet appearing in its place in the output order. A trigger sent one cycle later, when the queue is full and no pop happens, must instead raise the count.

// File: rtl/twx_pkg.sv
`timescale 1ns/1ps
package twx_pkg;

   // word type carried beside every output payload
   typedef enum logic [1:0] {
      KIND_NONE = 2'b00,
      KIND_HDR  = 2'b01,
      KIND_HIT  = 2'b10,
      KIND_TRL  = 2'b11
   } word_kind_e;

   typedef enum logic [1:0] {
      RO_IDLE = 2'b00,
      RO_HDR  = 2'b01,
      RO_SCAN = 2'b10,
      RO_TRL  = 2'b11
   } ro_state_e;

endpackage

// File: rtl/twx_page_store.sv
`timescale 1ns/1ps
module twx_page_store #(
   parameter int TS_W   = 16,
   parameter int SLOT_W = 8,
   parameter int HPS    = 8,
   parameter int DATA_W = 16,
   localparam int CNT_W = $clog2(HPS + 1),
   localparam int IDX_W = $clog2(HPS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [TS_W-1:0]   wr_slot,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [TS_W-1:0]   rd_slot,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [CNT_W-1:0]  rd_count,
   output logic [DATA_W-1:0] rd_data
);

   localparam int SLOTS  = 2 ** SLOT_W;
   localparam int ADDR_W = SLOT_W + IDX_W;

   logic [TS_W-1:0]   tag_q [SLOTS];
   logic [CNT_W-1:0]  cnt_q [SLOTS];
   logic [DATA_W-1:0] dat_q [SLOTS*HPS];

   logic [SLOT_W-1:0] wr_pg, rd_pg;
   logic              fresh, room;
   logic [IDX_W-1:0]  wr_pos;
   logic [ADDR_W-1:0] wr_addr, rd_addr;

   assign wr_pg   = wr_slot[SLOT_W-1:0];
   assign rd_pg   = rd_slot[SLOT_W-1:0];
   // a differing tag means the page belongs to an older pass of the ring
   assign fresh   = (tag_q[wr_pg] != wr_slot);
   assign room    = (cnt_q[wr_pg] < CNT_W'(HPS));
   assign wr_pos  = fresh ? '0 : cnt_q[wr_pg][IDX_W-1:0];
   assign wr_addr = {wr_pg, wr_pos};
   assign rd_addr = {rd_pg, rd_idx};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SLOTS; i++) begin
            tag_q[i] <= '0;
            cnt_q[i] <= '0;
         end
      end else if (wr_en) begin
         if (fresh) begin
            tag_q[wr_pg] <= wr_slot;
            cnt_q[wr_pg] <= CNT_W'(1);
         end else if (room) begin
            cnt_q[wr_pg] <= cnt_q[wr_pg] + CNT_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && (fresh || room))
         dat_q[wr_addr] <= wr_data;
   end

   assign rd_count = (tag_q[rd_pg] == rd_slot) ? cnt_q[rd_pg] : '0;
   assign rd_data  = dat_q[rd_addr];

endmodule

// File: rtl/twx_trig_fifo.sv
`timescale 1ns/1ps
module twx_trig_fifo #(
   parameter int W     = 22,
   parameter int DEPTH = 4,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [W-1:0]     din,
   output logic [W-1:0]     dout,
   output logic             empty,
   output logic             full,
   output logic [LVL_W-1:0] level
);

   localparam int PTR_W = $clog2(DEPTH);

   logic [W-1:0]     mem_q [DEPTH];
   logic [PTR_W-1:0] wp_q, rp_q;
   logic [LVL_W-1:0] lvl_q;

   function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         lvl_q <= '0;
      end else begin
         if (push) wp_q <= step_ptr(wp_q);
         if (pop)  rp_q <= step_ptr(rp_q);
         if (push && !pop)      lvl_q <= lvl_q + LVL_W'(1);
         else if (pop && !push) lvl_q <= lvl_q - LVL_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem_q[wp_q] <= din;
   end

   assign dout  = mem_q[rp_q];
   assign empty = (lvl_q == '0);
   assign full  = (lvl_q == LVL_W'(DEPTH));
   assign level = lvl_q;

endmodule

// File: rtl/twx_readout.sv
`timescale 1ns/1ps
module twx_readout #(
   parameter int TS_W   = 16,
   parameter int HPS    = 8,
   parameter int DATA_W = 16,
   parameter int WIN_W  = 3,
   parameter int OUT_W  = 16,
   localparam int CNT_W = $clog2(HPS + 1),
   localparam int IDX_W = $clog2(HPS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TS_W-1:0]   now_slot,
   input  logic              head_valid,
   input  logic [TS_W-1:0]   head_slot,
   input  logic [WIN_W-1:0]  head_before,
   input  logic [WIN_W-1:0]  head_after,
   output logic              pop,
   output logic [TS_W-1:0]   rd_slot,
   output logic [IDX_W-1:0]  rd_idx,
   input  logic [CNT_W-1:0]  rd_count,
   input  logic [DATA_W-1:0] rd_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [1:0]        out_kind,
   output logic [OUT_W-1:0]  out_data,
   output logic              out_last,
   output logic              scan_active
);
   import twx_pkg::*;

   localparam int MAX_HITS = (2 * (2 ** WIN_W - 1) + 1) * HPS;
   localparam int TOT_W    = $clog2(MAX_HITS + 1);

   ro_state_e        st_q;
   logic [TS_W-1:0]  trig_q, cur_q, last_q;
   logic [CNT_W-1:0] idx_q;
   logic [TOT_W-1:0] tot_q;

   logic [TS_W-1:0]  head_last, gap;
   logic             head_closed, have_hit;

   // modular distance from the window's last slot to the present
   assign head_last   = head_slot + TS_W'(head_after);
   assign gap         = now_slot - head_last;
   assign head_closed = !gap[TS_W-1] && (gap != '0);
   assign pop         = (st_q == RO_IDLE) && head_valid && head_closed;

   assign rd_slot     = cur_q;
   assign rd_idx      = idx_q[IDX_W-1:0];
   assign have_hit    = (idx_q < rd_count);
   assign scan_active = (st_q == RO_SCAN);

   always_comb begin
      out_valid = 1'b0;
      out_kind  = KIND_NONE;
      out_data  = '0;
      out_last  = 1'b0;
      unique case (st_q)
         RO_HDR: begin
            out_valid = 1'b1;
            out_kind  = KIND_HDR;
            out_data  = OUT_W'(trig_q);
         end
         RO_SCAN: begin
            if (have_hit) begin
               out_valid = 1'b1;
               out_kind  = KIND_HIT;
               out_data  = OUT_W'(rd_data);
            end
         end
         RO_TRL: begin
            out_valid = 1'b1;
            out_kind  = KIND_TRL;
            out_data  = OUT_W'(tot_q);
            out_last  = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= RO_IDLE;
         trig_q <= '0;
         cur_q  <= '0;
         last_q <= '0;
         idx_q  <= '0;
         tot_q  <= '0;
      end else begin
         unique case (st_q)
            RO_IDLE: begin
               if (pop) begin
                  trig_q <= head_slot;
                  cur_q  <= head_slot - TS_W'(head_before);
                  last_q <= head_last;
                  idx_q  <= '0;
                  tot_q  <= '0;
                  st_q   <= RO_HDR;
               end
            end
            RO_HDR: begin
               if (out_ready) st_q <= RO_SCAN;
            end
            RO_SCAN: begin
               if (have_hit) begin
                  if (out_ready) begin
                     idx_q <= idx_q + CNT_W'(1);
                     tot_q <= tot_q + TOT_W'(1);
                  end
               end else if (cur_q == last_q) begin
                  st_q <= RO_TRL;
               end else begin
                  cur_q <= cur_q + TS_W'(1);
                  idx_q <= '0;
               end
            end
            RO_TRL: begin
               if (out_ready) st_q <= RO_IDLE;
            end
            default: st_q <= RO_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/trig_window_extractor.sv
`timescale 1ns/1ps
module trig_window_extractor #(
   parameter int TS_W    = 16,
   parameter int SLOT_W  = 8,
   parameter int HPS     = 8,
   parameter int DATA_W  = 16,
   parameter int WIN_W   = 3,
   parameter int QDEPTH  = 4,
   parameter int ERR_W   = 8,
   parameter bit ERR_SAT = 1'b1,
   localparam int OUT_W  = (DATA_W > TS_W) ? DATA_W : TS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TS_W-1:0]   now_slot,
   input  logic              hit_valid,
   input  logic [TS_W-1:0]   hit_slot,
   input  logic [DATA_W-1:0] hit_data,
   input  logic              trig_valid,
   input  logic [TS_W-1:0]   trig_slot,
   input  logic [WIN_W-1:0]  win_before,
   input  logic [WIN_W-1:0]  win_after,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [1:0]        out_kind,
   output logic [OUT_W-1:0]  out_data,
   output logic              out_last,
   output logic [ERR_W-1:0]  err_count
);

   localparam int CNT_W = $clog2(HPS + 1);
   localparam int IDX_W = $clog2(HPS);
   localparam int ENT_W = TS_W + 2 * WIN_W;
   localparam int LVL_W = $clog2(QDEPTH + 1);

   // elaboration-time parameter checks
   if (SLOT_W >= TS_W) begin : g_bad_slot
      $error("SLOT_W must be narrower than TS_W");
   end
   if (HPS < 2 || (HPS & (HPS - 1)) != 0) begin : g_bad_hps
      $error("HPS must be a power of two of at least 2");
   end
   if (QDEPTH < 2) begin : g_bad_depth
      $error("QDEPTH must be at least 2");
   end
   if (2 ** (WIN_W + 1) >= 2 ** SLOT_W) begin : g_bad_win
      $error("window span must fit well inside the slot ring");
   end

   logic              q_push, q_pop, q_empty, q_full;
   logic [LVL_W-1:0]  q_level;
   logic [ENT_W-1:0]  q_din, q_dout;
   logic              drop;
   logic              scan_active;
   logic [TS_W-1:0]   ro_slot;
   logic [IDX_W-1:0]  ro_idx;
   logic [CNT_W-1:0]  st_count;
   logic [DATA_W-1:0] st_data;

   assign q_din  = {trig_slot, win_before, win_after};
   assign q_push = trig_valid && (!q_full || q_pop);
   assign drop   = trig_valid && q_full && !q_pop;

   twx_page_store #(
      .TS_W(TS_W), .SLOT_W(SLOT_W), .HPS(HPS), .DATA_W(DATA_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (hit_valid),
      .wr_slot  (hit_slot),
      .wr_data  (hit_data),
      .rd_slot  (ro_slot),
      .rd_idx   (ro_idx),
      .rd_count (st_count),
      .rd_data  (st_data)
   );

   twx_trig_fifo #(
      .W(ENT_W), .DEPTH(QDEPTH)
   ) u_queue (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (q_push),
      .pop   (q_pop),
      .din   (q_din),
      .dout  (q_dout),
      .empty (q_empty),
      .full  (q_full),
      .level (q_level)
   );

   twx_readout #(
      .TS_W(TS_W), .HPS(HPS), .DATA_W(DATA_W), .WIN_W(WIN_W), .OUT_W(OUT_W)
   ) u_readout (
      .clk         (clk),
      .rst_n       (rst_n),
      .now_slot    (now_slot),
      .head_valid  (!q_empty),
      .head_slot   (q_dout[ENT_W-1 -: TS_W]),
      .head_before (q_dout[2*WIN_W-1 -: WIN_W]),
      .head_after  (q_dout[WIN_W-1:0]),
      .pop         (q_pop),
      .rd_slot     (ro_slot),
      .rd_idx      (ro_idx),
      .rd_count    (st_count),
      .rd_data     (st_data),
      .out_valid   (out_valid),
      .out_ready   (out_ready),
      .out_kind    (out_kind),
      .out_data    (out_data),
      .out_last    (out_last),
      .scan_active (scan_active)
   );

   logic [ERR_W-1:0] err_q;

   if (ERR_SAT) begin : g_err_sat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   err_q <= '0;
         else if (drop && (err_q != '1)) err_q <= err_q + ERR_W'(1);
      end
   end else begin : g_err_wrap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    err_q <= '0;
         else if (drop) err_q <= err_q + ERR_W'(1);
      end
   end

   assign err_count = err_q;

endmodule

// File: rtl/twx_checker.sv
`timescale 1ns/1ps
module twx_checker #(
   parameter int TS_W   = 16,
   parameter int OUT_W  = 16,
   parameter int QDEPTH = 4,
   parameter int ERR_W  = 8,
   localparam int LVL_W = $clog2(QDEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [TS_W-1:0]  now_slot,
   input logic             trig_valid,
   input logic             q_full,
   input logic             q_pop,
   input logic [LVL_W-1:0] q_level,
   input logic             scan_active,
   input logic [TS_W-1:0]  ro_slot,
   input logic             out_valid,
   input logic             out_ready,
   input logic [1:0]       out_kind,
   input logic [OUT_W-1:0] out_data,
   input logic             out_last,
   input logic [ERR_W-1:0] err_count
);

   logic [TS_W-1:0] lead;
   logic            rejected;
   assign lead     = now_slot - ro_slot;
   assign rejected = trig_valid && q_full && !q_pop;

   a_r8_queue_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      q_level <= LVL_W'(QDEPTH));

   a_r9_drop_counts: assert property (@(posedge clk) disable iff (!rst_n)
      rejected && (err_count != '1) |=> err_count == $past(err_count) + ERR_W'(1));

   a_r9_count_only_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
      !rejected |=> $stable(err_count));

   a_r6_scan_in_past: assert property (@(posedge clk) disable iff (!rst_n)
      scan_active |-> (!lead[TS_W-1] && (lead != '0)));

   a_r7_hold_framing: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready && (out_kind != 2'b10)
      |=> out_valid && $stable(out_kind) && $stable(out_data));

   a_r7_trailer_closes: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_last |=> !out_valid);

   a_r7_last_on_trailer: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid && (out_kind == 2'b11));

endmodule

bind trig_window_extractor twx_checker #(
   .TS_W(TS_W), .OUT_W(OUT_W), .QDEPTH(QDEPTH), .ERR_W(ERR_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .now_slot    (now_slot),
   .trig_valid  (trig_valid),
   .q_full      (q_full),
   .q_pop       (q_pop),
   .q_level     (q_level),
   .scan_active (scan_active),
   .ro_slot     (ro_slot),
   .out_valid   (out_valid),
   .out_ready   (out_ready),
   .out_kind    (out_kind),
   .out_data    (out_data),
   .out_last    (out_last),
   .err_count   (err_count)
);

// File: tb/test_trig_window_extractor.sv
`timescale 1ns/1ps
module test_trig_window_extractor;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] now_slot = '0;
   logic        hit_valid = 1'b0;
   logic [15:0] hit_slot = '0;
   logic [15:0] hit_data = '0;
   logic        trig_valid = 1'b0;
   logic [15:0] trig_slot = '0;
   logic [2:0]  win_before = '0;
   logic [2:0]  win_after = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [1:0]  out_kind;
   logic [15:0] out_data;
   logic        out_last;
   logic [7:0]  err_count;

   trig_window_extractor i_trig_window_extractor (
      .clk(clk), .rst_n(rst_n), .now_slot(now_slot),
      .hit_valid(hit_valid), .hit_slot(hit_slot), .hit_data(hit_data),
      .trig_valid(trig_valid), .trig_slot(trig_slot),
      .win_before(win_before), .win_after(win_after),
      .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
      .out_data(out_data), .out_last(out_last), .err_count(err_count)
   );

   always #2 clk = ~clk;

   int    n_tests = 0;
   int    n_fail = 0;
   string tag = "R1";
   int    now = 0;
   int    ready_mode = 0;
   int    cyc = 0;

   // reference model state
   int          err_exp = 0;
   bit          busy = 0;
   int          pend_s[$];
   int          pend_b[$];
   int          pend_a[$];
   logic [17:0] expq[$];
   logic [15:0] hv[int];
   int          hn[int];
   int          lastw[int];
   int          packets = 0;
   bit          pop_e;
   int          qsz, ms, mb, ma, tot, hs, pg;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   task automatic step(input bit hvld, input logic [15:0] hd,
                       input bit tvld, input int ts, input int wb, input int wa);
      @(posedge clk);
      #1;
      cyc++;
      now_slot   = 16'(now);
      hit_valid  = hvld;
      hit_slot   = 16'(now);
      hit_data   = hd;
      trig_valid = tvld;
      trig_slot  = 16'(ts);
      win_before = 3'(wb);
      win_after  = 3'(wa);
      out_ready  = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? 1'(cyc % 3 != 0) : 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0, 0);
   endtask

   task automatic fill(input int n);
      for (int k = 0; k < n; k++) step(1, 16'((now << 4) + k), 0, 0, 0, 0);
   endtask

   // model: evaluated half a cycle before each rising edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk(err_count == 8'(err_exp), "R9", "err_count", int'(err_count), err_exp);
         if (!busy) chk(out_valid == 1'b0, "R6", "out_valid while idle", int'(out_valid), 0);
         qsz   = pend_s.size();
         pop_e = !busy && (qsz > 0) && (int'(now_slot) > pend_s[0] + pend_a[0]);
         if (out_valid) begin
            if (expq.size() == 0) begin
               chk(1'b0, tag, "unexpected word", int'({out_kind, out_data}), 0);
            end else begin
               chk({out_kind, out_data} == expq[0], tag, "packet word",
                   int'({out_kind, out_data}), int'(expq[0]));
               chk(out_last == (out_kind == 2'b11), "R7", "out_last", int'(out_last),
                   int'(out_kind == 2'b11));
               if (out_ready) begin
                  if (expq[0][17:16] == 2'b11) begin
                     busy = 0;
                     packets++;
                  end
                  void'(expq.pop_front());
               end
            end
         end
         if (pop_e) begin
            ms = pend_s.pop_front();
            mb = pend_b.pop_front();
            ma = pend_a.pop_front();
            tot = 0;
            expq.push_back({2'b01, 16'(ms)});
            for (int x = ms - mb; x <= ms + ma; x++) begin
               if (lastw.exists(x % 256) && lastw[x % 256] == x)
                  for (int k = 0; k < hn[x]; k++) begin
                     expq.push_back({2'b10, hv[x * 8 + k]});
                     tot++;
                  end
            end
            expq.push_back({2'b11, 16'(tot)});
            busy = 1;
         end
         if (trig_valid) begin
            if (qsz < 4 || pop_e) begin
               pend_s.push_back(int'(trig_slot));
               pend_b.push_back(int'(win_before));
               pend_a.push_back(int'(win_after));
            end else if (err_exp < 255) begin
               err_exp++;
            end
         end
         if (hit_valid) begin
            hs = int'(hit_slot);
            pg = hs % 256;
            if (lastw.exists(pg) && lastw[pg] == hs) begin
               if (hn[hs] < 8) begin
                  hv[hs * 8 + hn[hs]] = hit_data;
                  hn[hs]++;
               end
            end else begin
               lastw[pg] = hs;
               hn[hs] = 1;
               hv[hs * 8] = hit_data;
            end
         end
      end
   end

   initial begin
      #800000;
      chk(1'b0, "R1", "watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
      chk(err_count == 8'd0, "R1", "err_count in reset", int'(err_count), 0);
      @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

      // slot sorting, plain window, pending trigger
      tag = "R2/R11";
      for (int s = 10; s < 30; s++) begin
         now = s;
         if (s == 22)      step(0, '0, 1, 20, 2, 1);
         else if (s == 25) begin tag = "R6"; step(0, '0, 1, 25, 0, 3); end
         else              step(0, '0, 0, 0, 0, 0);
         fill(s % 4);
      end
      now = 30;
      idle(40);

      // per-slot cap with backpressure
      tag = "R4/R7";
      ready_mode = 1;
      now = 40;
      fill(11);
      now = 41;
      fill(1);
      step(0, '0, 1, 40, 0, 0);
      now = 42;
      fill(1);
      idle(40);

      // widest window
      tag = "R3";
      now = 43;
      step(0, '0, 1, 35, 7, 7);
      idle(60);

      // page reuse after a full ring pass
      tag = "R5";
      ready_mode = 0;
      now = 50;
      fill(3);
      for (int s = 51; s < 306; s++) begin
         now = s;
         step(0, '0, 0, 0, 0, 0);
      end
      now = 306;
      fill(2);
      now = 308;
      step(0, '0, 1, 50, 0, 0);
      step(0, '0, 1, 306, 0, 0);
      idle(30);

      // queueing, drops and simultaneous pop with push
      tag = "R8/R10";
      now = 320;
      ready_mode = 2;
      step(0, '0, 1, 319, 0, 0);
      idle(2);
      for (int i = 0; i < 4; i++) step(0, '0, 1, 330, i, 0);
      step(0, '0, 1, 330, 0, 0);
      ready_mode = 0;
      idle(10);
      ready_mode = 2;
      now = 331;
      step(0, '0, 1, 331, 1, 0);
      step(0, '0, 1, 331, 2, 0);
      for (int i = 0; i < 260; i++) step(0, '0, 1, 331, 0, 0);
      ready_mode = 0;
      now = 340;
      idle(200);

      @(negedge clk);
      chk(err_count == 8'd255, "R9", "saturated drop count", int'(err_count), 255);
      chk(expq.size() == 0, "R8", "words left over", expq.size(), 0);
      chk(pend_s.size() == 0, "R8", "triggers left over", pend_s.size(), 0);
      chk(packets == 12, "R8", "packets delivered", packets, 12);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule